// File: doc/BRIEF.md
# Low-Frequency RFID Downlink Command Sequencer

This block drives the carrier-enable line of a 125 kHz reader so that one command frame reaches a low-frequency tag. The frame is sent by gating the field on and off. A start strobe latches the command, the operands and the password option. The block then runs the whole sequence on its own and reports the end with a one-cycle pulse.

Every command uses the same steps:
- a long powered settle period,
- a start gap with the field off,
- the frame bits, each sent as a field-on period followed by a short field-off gap. A 0 uses a short on time and a 1 uses a long on time.

Three commands are supported: page-0 block write, page-0 block read, and page-1 trace read. They differ in which fields the frame carries. They also differ in what happens after the frame:
- A write holds the field on to cover the tag's programming time, then turns it off.
- A read leaves the field on so the tag can answer. The done pulse then opens the capture window for downstream sampling logic.

All durations are parameters counted in carrier cycles. One carrier cycle is `CARRIER_DIV` base clocks, with a default of 95.

Top module: `lfdl_downlink`

## Requirements
- R1: After reset, `field_en_o`, `busy_o` and `done_o` are all 0.
- R2: A `start_i` accepted while idle raises `busy_o` and turns the field on from the accepting edge. The field then stays on for `SETTLE_CYC*CARRIER_DIV` clocks.
- R3: After the settle period, the field is off for `START_GAP_CYC*CARRIER_DIV` clocks.
- R4: Each frame bit is sent as a field-on period followed by a field-off period of `WGAP_CYC*CARRIER_DIV` clocks. The on period is `ON0_CYC*CARRIER_DIV` clocks for a 0 and `ON1_CYC*CARRIER_DIV` clocks for a 1.
- R5: Every frame begins with the bit 1 and then a page bit. The page bit is 0 for block write and block read, and 1 for trace read. A trace-read frame ends after these two bits.
- R6: For block write and block read with `pw_en_i`=1, the 32 password bits follow the page bit, most-significant bit first. Trace read ignores `pw_en_i` and `pw_i`.
- R7: Block commands then send a lock bit of 0.
  - A write next sends the 32 data bits, then the 3 block-address bits, both most-significant bit first.
  - A read sends only the 3 block-address bits after the lock bit.
- R8: After the last gap of a write frame, the field is on for `PROG_CYC*CARRIER_DIV` clocks. The field then turns off, and `done_o` pulses on that same edge while `busy_o` falls.
- R9: After the last gap of a read or trace frame, the field turns on and stays on. `done_o` pulses on that same edge and `busy_o` falls.
- R10: `done_o` is high for exactly one clock per command and never at any other time.
- R11: While busy, `start_i` is ignored. Changes to the command, data, password or block inputs during a frame have no effect on it.
- R12: The command encoding on `cmd_i` is 2'b00 = block write, 2'b01 = block read, 2'b10 or 2'b11 = trace read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one clock |
| cmd_i | input | 2 | Command select |
| pw_en_i | input | 1 | Include password in block commands |
| pw_i | input | 32 | Password word |
| data_i | input | 32 | Data word for block write |
| blk_i | input | 3 | Block address |
| field_en_o | output | 1 | Carrier field enable |
| busy_o | output | 1 | Command sequence in progress |
| done_o | output | 1 | End-of-command pulse; opens the response window on reads |

## Verification
The bench sweeps every command code, both password settings and all eight block addresses. It compares the field level on every clock against a waveform it builds from the frame bits. Because 0 and 1 have different on times, any wrong, missing or reordered bit shows up as a mismatch.

The password sweep separates frames with and without the 32 password bits. Using both trace codes with the password enabled shows that the trace frame ignores the password. Changing the data and block values from run to run exposes bit-order and field-order errors.

The write and read runs show the two different post-frame behaviours. A separate run changes the inputs and pulses the start strobe mid-frame, and must leave that frame unchanged.

// File: rtl/lfdl_pkg.sv
package lfdl_pkg;

  typedef enum logic [1:0] {
    CMD_WRITE = 2'b00,
    CMD_READ  = 2'b01,
    CMD_TRACE = 2'b10
  } lfdl_cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETTLE,
    PH_SGAP,
    PH_BON,
    PH_BGAP,
    PH_PROG
  } lfdl_phase_e;

endpackage

// File: rtl/lfdl_phase_timer.sv
module lfdl_phase_timer #(
  parameter int CARRIER_DIV = 95,
  parameter int TW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          expire_o
);

  localparam int PREW = (CARRIER_DIV > 1) ? $clog2(CARRIER_DIV) : 1;
  localparam logic [PREW-1:0] PRE_LAST = PREW'(CARRIER_DIV - 1);

  logic [PREW-1:0] pre_q, pre_n;
  logic [TW-1:0]   cnt_q, cnt_n;

  always_comb begin
    pre_n = pre_q;
    cnt_n = cnt_q;
    if (load_i) begin
      pre_n = '0;
      cnt_n = len_i;
    end else if (cnt_q != '0) begin
      if (pre_q == PRE_LAST) begin
        pre_n = '0;
        cnt_n = cnt_q - 1'b1;
      end else begin
        pre_n = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_n;
      cnt_q <= cnt_n;
    end
  end

  assign expire_o = (cnt_q == TW'(1)) && (pre_q == PRE_LAST);

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (len_i != '0)); // R4

endmodule

// File: rtl/lfdl_framer.sv
module lfdl_framer
  import lfdl_pkg::*;
#(
  parameter int PW_W = 32,
  parameter int DW   = 32,
  parameter int BW   = 3,
  parameter int FW   = 3 + PW_W + DW + BW,
  parameter int LW   = $clog2(FW + 1)
) (
  input  lfdl_cmd_e       cmd_i,
  input  logic            pw_en_i,
  input  logic [PW_W-1:0] pw_i,
  input  logic [DW-1:0]   data_i,
  input  logic [BW-1:0]   blk_i,
  output logic [FW-1:0]   frame_o,
  output logic [LW-1:0]   len_o
);

  localparam logic [LW-1:0] LEN_TRACE = LW'(2);
  localparam logic [LW-1:0] LEN_RD    = LW'(3 + BW);
  localparam logic [LW-1:0] LEN_RD_PW = LW'(3 + PW_W + BW);
  localparam logic [LW-1:0] LEN_WR    = LW'(3 + DW + BW);
  localparam logic [LW-1:0] LEN_WR_PW = LW'(FW);

  always_comb begin
    unique case (cmd_i)
      CMD_WRITE: begin
        if (pw_en_i) begin
          frame_o = {2'b10, pw_i, 1'b0, data_i, blk_i};
          len_o   = LEN_WR_PW;
        end else begin
          frame_o = {2'b10, 1'b0, data_i, blk_i, {PW_W{1'b0}}};
          len_o   = LEN_WR;
        end
      end
      CMD_READ: begin
        if (pw_en_i) begin
          frame_o = {2'b10, pw_i, 1'b0, blk_i, {DW{1'b0}}};
          len_o   = LEN_RD_PW;
        end else begin
          frame_o = {2'b10, 1'b0, blk_i, {(PW_W + DW){1'b0}}};
          len_o   = LEN_RD;
        end
      end
      default: begin
        frame_o = {2'b11, {(FW - 2){1'b0}}};
        len_o   = LEN_TRACE;
      end
    endcase
  end

endmodule

// File: rtl/lfdl_downlink.sv
module lfdl_downlink
  import lfdl_pkg::*;
#(
  parameter int CARRIER_DIV   = 95,
  parameter int SETTLE_CYC    = 18750,
  parameter int START_GAP_CYC = 30,
  parameter int ON0_CYC       = 24,
  parameter int ON1_CYC       = 54,
  parameter int WGAP_CYC      = 20,
  parameter int PROG_CYC      = 2500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [1:0]  cmd_i,
  input  logic        pw_en_i,
  input  logic [31:0] pw_i,
  input  logic [31:0] data_i,
  input  logic [2:0]  blk_i,
  output logic        field_en_o,
  output logic        busy_o,
  output logic        done_o
);

  localparam int PW_W = 32;
  localparam int DW   = 32;
  localparam int BW   = 3;
  localparam int FW   = 3 + PW_W + DW + BW;
  localparam int LW   = $clog2(FW + 1);

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LEN_MAX = imax(imax(imax(SETTLE_CYC, START_GAP_CYC), imax(ON0_CYC, ON1_CYC)),
                                imax(WGAP_CYC, PROG_CYC));
  localparam int TW = $clog2(LEN_MAX + 1);

  localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_CYC);
  localparam logic [TW-1:0] T_SGAP   = TW'(START_GAP_CYC);
  localparam logic [TW-1:0] T_ON0    = TW'(ON0_CYC);
  localparam logic [TW-1:0] T_ON1    = TW'(ON1_CYC);
  localparam logic [TW-1:0] T_WGAP   = TW'(WGAP_CYC);
  localparam logic [TW-1:0] T_PROG   = TW'(PROG_CYC);

  lfdl_phase_e     state_q, state_n;
  logic [LW-1:0]   idx_q, idx_n;
  logic            field_q, field_n;
  logic            done_q, done_n;
  lfdl_cmd_e       cmd_q;
  logic            pwen_q;
  logic [PW_W-1:0] pw_q;
  logic [DW-1:0]   data_q;
  logic [BW-1:0]   blk_q;

  logic            accept;
  logic            tmr_load;
  logic [TW-1:0]   tmr_len;
  logic            tmr_exp;
  logic [FW-1:0]   frame;
  logic [LW-1:0]   frame_len;
  logic [LW-1:0]   nxt_idx;
  logic            nxt_bit;
  logic            last_bit;

  assign accept = (state_q == PH_IDLE) && start_i;

  // Operand capture, enabled only by an accepted strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_WRITE;
      pwen_q <= 1'b0;
      pw_q   <= '0;
      data_q <= '0;
      blk_q  <= '0;
    end else if (accept) begin
      cmd_q  <= cmd_i[1] ? CMD_TRACE : lfdl_cmd_e'(cmd_i);
      pwen_q <= pw_en_i;
      pw_q   <= pw_i;
      data_q <= data_i;
      blk_q  <= blk_i;
    end
  end

  lfdl_framer #(.PW_W(PW_W), .DW(DW), .BW(BW), .FW(FW), .LW(LW)) u_framer (
    .cmd_i   (cmd_q),
    .pw_en_i (pwen_q),
    .pw_i    (pw_q),
    .data_i  (data_q),
    .blk_i   (blk_q),
    .frame_o (frame),
    .len_o   (frame_len)
  );

  lfdl_phase_timer #(.CARRIER_DIV(CARRIER_DIV), .TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .len_i    (tmr_len),
    .expire_o (tmr_exp)
  );

  assign nxt_idx  = (state_q == PH_SGAP) ? '0 : idx_q + 1'b1;
  assign nxt_bit  = (nxt_idx < LW'(FW)) ? frame[FW - 1 - int'(nxt_idx)] : 1'b0;
  assign last_bit = (idx_q == frame_len - 1'b1);

  always_comb begin
    state_n  = state_q;
    idx_n    = idx_q;
    field_n  = field_q;
    done_n   = 1'b0;
    tmr_load = 1'b0;
    tmr_len  = '0;
    unique case (state_q)
      PH_IDLE: begin
        if (start_i) begin
          state_n  = PH_SETTLE;
          field_n  = 1'b1;
          tmr_load = 1'b1;
          tmr_len  = T_SETTLE;
        end
      end
      PH_SETTLE: begin
        if (tmr_exp) begin
          state_n  = PH_SGAP;
          field_n  = 1'b0;
          tmr_load = 1'b1;
          tmr_len  = T_SGAP;
        end
      end
      PH_SGAP: begin
        if (tmr_exp) begin
          state_n  = PH_BON;
          idx_n    = nxt_idx;
          field_n  = 1'b1;
          tmr_load = 1'b1;
          tmr_len  = nxt_bit ? T_ON1 : T_ON0;
        end
      end
      PH_BON: begin
        if (tmr_exp) begin
          state_n  = PH_BGAP;
          field_n  = 1'b0;
          tmr_load = 1'b1;
          tmr_len  = T_WGAP;
        end
      end
      PH_BGAP: begin
        if (tmr_exp) begin
          field_n = 1'b1;
          if (!last_bit) begin
            state_n  = PH_BON;
            idx_n    = nxt_idx;
            tmr_load = 1'b1;
            tmr_len  = nxt_bit ? T_ON1 : T_ON0;
          end else if (cmd_q == CMD_WRITE) begin
            state_n  = PH_PROG;
            tmr_load = 1'b1;
            tmr_len  = T_PROG;
          end else begin
            state_n = PH_IDLE;
            done_n  = 1'b1;
          end
        end
      end
      PH_PROG: begin
        if (tmr_exp) begin
          state_n = PH_IDLE;
          field_n = 1'b0;
          done_n  = 1'b1;
        end
      end
      default: begin
        state_n = PH_IDLE;
        field_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      idx_q   <= '0;
      field_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      field_q <= field_n;
      done_q  <= done_n;
    end
  end

  assign field_en_o = field_q;
  assign busy_o     = (state_q != PH_IDLE);
  assign done_o     = done_q;

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(cmd_q) && $stable(data_q) && $stable(pw_q) && $stable(blk_q))); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R8

  AST_WRITE_FIELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cmd_q == CMD_WRITE) |-> !field_en_o); // R8

  AST_READ_FIELD_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cmd_q != CMD_WRITE) |-> field_en_o); // R9

  AST_GAP_FIELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_SGAP || state_q == PH_BGAP) |-> !field_en_o); // R3

  AST_IDX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_BON || state_q == PH_BGAP) |-> (idx_q < frame_len)); // R5

endmodule

// File: tb/sim_lfdl_downlink.sv
`timescale 1ns/1ps
module sim_lfdl_downlink;

  localparam int DIV    = 2;
  localparam int SETTLE = 3;
  localparam int SGAP   = 2;
  localparam int ON0    = 1;
  localparam int ON1    = 2;
  localparam int WGAP   = 1;
  localparam int PROG   = 4;
  localparam int POST   = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  cmd;
  logic        pw_en;
  logic [31:0] pw;
  logic [31:0] data;
  logic [2:0]  blk;
  logic        field_en;
  logic        busy;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int    seg_len [0:255];
  bit    seg_lvl [0:255];
  string seg_tag [0:255];
  int    nseg;

  always #2.5 clk = ~clk;

  lfdl_downlink #(
    .CARRIER_DIV(DIV), .SETTLE_CYC(SETTLE), .START_GAP_CYC(SGAP),
    .ON0_CYC(ON0), .ON1_CYC(ON1), .WGAP_CYC(WGAP), .PROG_CYC(PROG)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd), .pw_en_i(pw_en),
    .pw_i(pw), .data_i(data), .blk_i(blk),
    .field_en_o(field_en), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic add_seg(input bit lvl, input int len, input string tag);
    seg_lvl[nseg] = lvl;
    seg_len[nseg] = len;
    seg_tag[nseg] = tag;
    nseg++;
  endtask

  task automatic add_bit(input bit b, input string tag);
    add_seg(1'b1, (b ? ON1 : ON0) * DIV, tag);   // R4 on time by bit value
    add_seg(1'b0, WGAP * DIV, "R4");
  endtask

  // Run one command and compare the field on every clock with the expected waveform
  task automatic run_cmd(input logic [1:0] c, input logic pe, input logic [31:0] p,
                         input logic [31:0] d, input logic [2:0] b, input bit disturb);
    int t_done;
    int s;
    bit is_trace;
    bit done_ok;
    int done_cnt;
    is_trace = c[1];
    nseg = 0;
    add_seg(1'b1, SETTLE * DIV, "R2");
    add_seg(1'b0, SGAP * DIV, "R3");
    add_bit(1'b1, "R5");
    add_bit(is_trace, "R12");
    if (!is_trace) begin
      if (pe) for (int i = 31; i >= 0; i--) add_bit(p[i], "R6");
      add_bit(1'b0, "R7");
      if (c == 2'b00) for (int i = 31; i >= 0; i--) add_bit(d[i], "R7");
      for (int i = 2; i >= 0; i--) add_bit(b[i], "R7");
    end
    t_done = 0;
    for (int i = 0; i < nseg; i++) t_done += seg_len[i];
    if (c == 2'b00) begin
      add_seg(1'b1, PROG * DIV, "R8");
      t_done += PROG * DIV;
      add_seg(1'b0, POST, "R8");
    end else begin
      add_seg(1'b1, POST, "R9");
    end

    @(negedge clk);
    cmd = c; pw_en = pe; pw = p; data = d; blk = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    s = 0;
    done_ok = 1'b1;
    done_cnt = 0;
    for (int g = 0; g < nseg; g++) begin
      bit bad;
      int bad_act;
      bad = 1'b0;
      bad_act = 0;
      for (int k = 0; k < seg_len[g]; k++) begin
        if (field_en !== seg_lvl[g] && !bad) begin
          bad = 1'b1;
          bad_act = int'(field_en);
        end
        if (done === 1'b1) done_cnt++;
        if ((done === 1'b1) != (s == t_done)) done_ok = 1'b0;
        if (s == 0) chk(busy === 1'b1, "R2", int'(busy), 1, "busy after start");
        if (s == t_done) begin
          if (c == 2'b00) chk(busy === 1'b0, "R8", int'(busy), 0, "busy at write done");
          else            chk(busy === 1'b0, "R9", int'(busy), 0, "busy at read done");
        end
        if (disturb && s == 4) begin
          // R11: new operands and a second strobe mid-frame
          cmd = ~c; pw_en = ~pe; pw = ~p; data = ~d; blk = ~b; start = 1'b1;
        end
        if (disturb && s == 5) start = 1'b0;
        s++;
        @(negedge clk);
      end
      chk(!bad, disturb ? "R11" : seg_tag[g], bad_act, int'(seg_lvl[g]), "field level in segment");
    end
    chk(done_ok && done_cnt == 1, "R10", done_cnt, 1, "done pulses at expected clock");
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    cmd = 2'b00; pw_en = 1'b0; pw = '0; data = '0; blk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(field_en === 1'b0, "R1", int'(field_en), 0, "field after reset");
    chk(busy === 1'b0,     "R1", int'(busy), 0, "busy after reset");
    chk(done === 1'b0,     "R1", int'(done), 0, "done after reset");

    for (int c = 0; c < 4; c++) begin
      for (int pe = 0; pe < 2; pe++) begin
        for (int b = 0; b < 8; b++) begin
          logic [31:0] pv;
          logic [31:0] dv;
          pv = 32'h1357_9BDF ^ {b[2:0], 29'd0} ^ (32'h0101_0101 << c);
          dv = 32'hC3A5_0F96 ^ {29'd0, b[2:0]} ^ (32'h8000_0001 * (c + pe));
          run_cmd(c[1:0], pe[0], pv, dv, b[2:0], 1'b0);
        end
      end
    end

    run_cmd(2'b00, 1'b0, 32'h0, 32'h0000_0000, 3'b000, 1'b0);   // R7 all-zero write
    run_cmd(2'b00, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b111, 1'b0); // R6 all-one write
    run_cmd(2'b00, 1'b1, 32'h8000_0001, 32'h4000_0002, 3'b101, 1'b1); // R11 write
    run_cmd(2'b01, 1'b0, 32'h2222_2222, 32'h1234_5678, 3'b010, 1'b1); // R11 read

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule